// File: doc/BRIEF.md
# Bit-Test, Compare and Branch-Condition Unit

This unit evaluates one operation per clock for an 8-bit accumulator processor core. It covers the bit-test family, the test-and-modify pair, single-bit clear and set, register-against-memory compares, a fused decrement-then-compare, and the branch-condition decode. The surrounding datapath supplies an operation code, the raw opcode byte, the A, X and Y registers, a memory operand and the current N, V, Z and C flags. The unit registers three results: the operand to write back, the new flag nibble and a branch-taken bit.

All results appear on the registered outputs after exactly one rising clock edge. Each cycle stands alone, because the unit keeps no state except its output register. A codes outside the defined set passes the operand and the flags through untouched and keeps branch-taken low. Instruction fetch and branch-target arithmetic belong to other blocks.

Operation codes (`op_code`): 0 no-op, 1 full bit test, 2 zero-only bit test, 3 test-and-reset, 4 test-and-set, 5 clear bit, 6 set bit, 7 compare A, 8 compare X, 9 compare Y, 10 decrement-and-compare, 16 branch if N clear, 17 branch if N set, 18 branch if V clear, 19 branch if V set, 20 branch if C clear, 21 branch if C set, 22 branch if Z clear, 23 branch if Z set, 24 branch always. Codes 11 to 15 and 25 to 31 are undefined. The flag nibble is ordered {N, V, Z, C} from bit 3 down to bit 0, and Z is 1 when a result is zero.

Top module: `bcu_top`

## Requirements
- R1: While `rst` is high, and after the first edge that samples it high, `opnd_q`, `flags_q` and `taken_q` are all zero.
- R2: Full bit test (code 1) sets Z when (operand AND A) is zero, copies operand bit 7 to N and operand bit 6 to V, and keeps C. Zero-only bit test (code 2) changes only Z, by the same rule. Both leave the operand unchanged.
- R3: Test-and-reset (code 3) and test-and-set (code 4) set Z by the R2 rule. They write back operand AND NOT A and operand OR A respectively, and keep N, V and C.
- R4: Clear bit (code 5) and set bit (code 6) clear or set the operand bit whose index is opcode bits 6 to 4. Every other operand bit and all four flags are unchanged.
- R5: Compares (codes 7, 8 and 9, against A, X and Y) set C when operand <= register and set Z and N from (register − operand) modulo 256. They keep V and leave the operand unchanged.
- R6: Decrement-and-compare (code 10) writes back (operand − 1) modulo 256. It then compares A against that decremented value using the R5 rule.
- R7: Branch codes 16 to 23 take the branch when, in order, N=0, N=1, V=0, V=1, C=0, C=1, Z=0, Z=1. Code 24 always takes the branch. Branch codes leave the operand and the flags unchanged.
- R8: `taken_q` is low in the cycle after any code that is not a branch code.
- R9: An undefined code drives `opnd_q` to the input operand and `flags_q` to the input flags.
- R10: Each result appears on the outputs after exactly one rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 5 | Operation select |
| opcode | input | 8 | Instruction byte; bits 6:4 give the bit index |
| reg_a | input | 8 | Accumulator |
| reg_x | input | 8 | X index register |
| reg_y | input | 8 | Y index register |
| opnd_in | input | 8 | Memory operand |
| flags_in | input | 4 | Current flags {N,V,Z,C} |
| opnd_q | output | 8 | Registered write-back operand |
| flags_q | output | 4 | Registered updated flags {N,V,Z,C} |
| taken_q | output | 1 | Registered branch-taken |

## Verification
The hardest cases to reach from the ports are the ones that hit a value boundary. Decrement-and-compare must wrap an operand of zero to 255 and then compare that against A. Compares must meet operand equal to the register, which is the only case where both C and Z are set. Uniform random operands almost never land on these values. The stimulus therefore draws operands and registers from a small pool of edge values (0, 1, 0x7F, 0x80, 0xFF) about half the time and sometimes copies the register into the operand. Directed vectors additionally pin down the zero wrap, the equal compare and every branch under both polarities of its flag.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
    localparam int unsigned OP_W = 5;

    localparam logic [OP_W-1:0] OP_NOP  = 5'd0;
    localparam logic [OP_W-1:0] OP_BITF = 5'd1;
    localparam logic [OP_W-1:0] OP_BITZ = 5'd2;
    localparam logic [OP_W-1:0] OP_TRST = 5'd3;
    localparam logic [OP_W-1:0] OP_TSET = 5'd4;
    localparam logic [OP_W-1:0] OP_BCLR = 5'd5;
    localparam logic [OP_W-1:0] OP_BSET = 5'd6;
    localparam logic [OP_W-1:0] OP_CMPA = 5'd7;
    localparam logic [OP_W-1:0] OP_CMPX = 5'd8;
    localparam logic [OP_W-1:0] OP_CMPY = 5'd9;
    localparam logic [OP_W-1:0] OP_DCMP = 5'd10;
    localparam logic [OP_W-1:0] OP_BR_FIRST = 5'd16;
    localparam logic [OP_W-1:0] OP_BR_ALWAYS = 5'd24;

    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } flags_t;

    typedef enum logic [1:0] {
        CLS_PASS,
        CLS_BITS,
        CLS_CMP,
        CLS_BRANCH
    } op_class_e;

    function automatic op_class_e classify(input logic [OP_W-1:0] op);
        op_class_e cls;
        if (op >= OP_BITF && op <= OP_BSET)
            cls = CLS_BITS;
        else if (op >= OP_CMPA && op <= OP_DCMP)
            cls = CLS_CMP;
        else if (op >= OP_BR_FIRST && op <= OP_BR_ALWAYS)
            cls = CLS_BRANCH;
        else
            cls = CLS_PASS;
        return cls;
    endfunction
endpackage

// File: rtl/bcu_bitops.sv
module bcu_bitops
    import bcu_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned IDX_W = $clog2(DATA_W)
) (
    input  logic [OP_W-1:0]   op,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] opnd_i,
    input  flags_t            flags_i,
    output logic [DATA_W-1:0] opnd_o,
    output flags_t            flags_o
);
    logic [DATA_W-1:0] sel_mask;
    logic              and_zero;

    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_mask
        assign sel_mask[gi] = (bit_idx == IDX_W'(gi));
    end

    assign and_zero = ((opnd_i & acc) == '0);

    always_comb begin
        opnd_o  = opnd_i;
        flags_o = flags_i;
        unique case (op)
            OP_BITF: begin
                flags_o.z = and_zero;
                flags_o.n = opnd_i[DATA_W-1];
                flags_o.v = opnd_i[DATA_W-2];
            end
            OP_BITZ: flags_o.z = and_zero;
            OP_TRST: begin
                flags_o.z = and_zero;
                opnd_o    = opnd_i & ~acc;
            end
            OP_TSET: begin
                flags_o.z = and_zero;
                opnd_o    = opnd_i | acc;
            end
            OP_BCLR: opnd_o = opnd_i & ~sel_mask;
            OP_BSET: opnd_o = opnd_i | sel_mask;
            default: ;
        endcase
    end

    // R4: the bit-select mask picks at most one bit
    always_comb begin
        a_mask_onehot_r4: assert ($onehot0(sel_mask));
    end
endmodule

// File: rtl/bcu_compare.sv
module bcu_compare
    import bcu_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] idx_x,
    input  logic [DATA_W-1:0] idx_y,
    input  logic [DATA_W-1:0] opnd_i,
    input  flags_t            flags_i,
    output logic [DATA_W-1:0] opnd_o,
    output flags_t            flags_o
);
    logic [DATA_W-1:0] lhs;
    logic [DATA_W-1:0] rhs;
    logic [DATA_W-1:0] diff;
    logic [DATA_W-1:0] dec_val;

    assign dec_val = opnd_i - DATA_W'(1);

    always_comb begin
        lhs = acc;
        rhs = opnd_i;
        unique case (op)
            OP_CMPX: lhs = idx_x;
            OP_CMPY: lhs = idx_y;
            OP_DCMP: rhs = dec_val;
            default: ;
        endcase
    end

    assign diff = lhs - rhs;

    always_comb begin
        opnd_o    = (op == OP_DCMP) ? dec_val : opnd_i;
        flags_o   = flags_i;
        flags_o.c = (rhs <= lhs);
        flags_o.z = (diff == '0);
        flags_o.n = diff[DATA_W-1];
    end
endmodule

// File: rtl/bcu_branch.sv
module bcu_branch
    import bcu_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  flags_t          flags_i,
    output logic            taken
);
    logic [2:0] cond_sel;
    logic       flag_bit;

    assign cond_sel = op[3:1];

    always_comb begin
        unique case (cond_sel[1:0])
            2'd0:    flag_bit = flags_i.n;
            2'd1:    flag_bit = flags_i.v;
            2'd2:    flag_bit = flags_i.c;
            default: flag_bit = flags_i.z;
        endcase
        if (op == OP_BR_ALWAYS)
            taken = 1'b1;
        else if (op >= OP_BR_FIRST && op < OP_BR_ALWAYS)
            taken = (flag_bit == op[0]);
        else
            taken = 1'b0;
    end
endmodule

// File: rtl/bcu_top.sv
module bcu_top
    import bcu_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned IDX_LSB = 4,
    localparam int unsigned IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [4:0]        op_code,
    input  logic [7:0]        opcode,
    input  logic [DATA_W-1:0] reg_a,
    input  logic [DATA_W-1:0] reg_x,
    input  logic [DATA_W-1:0] reg_y,
    input  logic [DATA_W-1:0] opnd_in,
    input  logic [3:0]        flags_in,
    output logic [DATA_W-1:0] opnd_q,
    output logic [3:0]        flags_q,
    output logic              taken_q
);
    flags_t            fl_in;
    op_class_e         cls;
    logic [DATA_W-1:0] bit_opnd, cmp_opnd, nxt_opnd;
    flags_t            bit_flags, cmp_flags, nxt_flags;
    logic              br_taken, nxt_taken;

    assign fl_in = flags_t'(flags_in);
    assign cls   = classify(op_code);

    bcu_bitops #(.DATA_W(DATA_W)) u_bitops (
        .op      (op_code),
        .bit_idx (opcode[IDX_LSB +: IDX_W]),
        .acc     (reg_a),
        .opnd_i  (opnd_in),
        .flags_i (fl_in),
        .opnd_o  (bit_opnd),
        .flags_o (bit_flags)
    );

    bcu_compare #(.DATA_W(DATA_W)) u_compare (
        .op      (op_code),
        .acc     (reg_a),
        .idx_x   (reg_x),
        .idx_y   (reg_y),
        .opnd_i  (opnd_in),
        .flags_i (fl_in),
        .opnd_o  (cmp_opnd),
        .flags_o (cmp_flags)
    );

    bcu_branch u_branch (
        .op      (op_code),
        .flags_i (fl_in),
        .taken   (br_taken)
    );

    always_comb begin
        nxt_opnd  = opnd_in;
        nxt_flags = fl_in;
        nxt_taken = 1'b0;
        unique case (cls)
            CLS_BITS: begin
                nxt_opnd  = bit_opnd;
                nxt_flags = bit_flags;
            end
            CLS_CMP: begin
                nxt_opnd  = cmp_opnd;
                nxt_flags = cmp_flags;
            end
            CLS_BRANCH: nxt_taken = br_taken;
            CLS_PASS: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            opnd_q  <= '0;
            flags_q <= '0;
            taken_q <= 1'b0;
        end else begin
            opnd_q  <= nxt_opnd;
            flags_q <= nxt_flags;
            taken_q <= nxt_taken;
        end
    end

    p_taken_nonbranch_r8: assert property (@(posedge clk) disable iff (rst)
        (classify(op_code) != CLS_BRANCH) |=> !taken_q);

    p_always_taken_r7: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_BR_ALWAYS) |=> taken_q);

    p_bitset_flags_r4: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_BCLR || op_code == OP_BSET) |=> (flags_q == $past(flags_in)));

    p_bitset_single_r4: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_BCLR || op_code == OP_BSET)
        |=> ($countones(opnd_q ^ $past(opnd_in)) <= 1));

    p_undefined_pass_r9: assert property (@(posedge clk) disable iff (rst)
        (classify(op_code) == CLS_PASS)
        |=> (opnd_q == $past(opnd_in) && flags_q == $past(flags_in)));

    p_cmp_keeps_v_r5: assert property (@(posedge clk) disable iff (rst)
        (classify(op_code) == CLS_CMP) |=> (flags_q[2] == $past(flags_in[2])));

    p_opcode_known_r4: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_BCLR || op_code == OP_BSET) |-> !$isunknown(opcode));
endmodule

// File: tb/test_bcu_top.sv
module test_bcu_top;
    logic       clk = 1'b0;
    logic       rst;
    logic [4:0] op_code;
    logic [7:0] opcode, reg_a, reg_x, reg_y, opnd_in;
    logic [3:0] flags_in;
    logic [7:0] opnd_q;
    logic [3:0] flags_q;
    logic       taken_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    bcu_top i_bcu_top (
        .clk(clk), .rst(rst), .op_code(op_code), .opcode(opcode),
        .reg_a(reg_a), .reg_x(reg_x), .reg_y(reg_y), .opnd_in(opnd_in),
        .flags_in(flags_in), .opnd_q(opnd_q), .flags_q(flags_q), .taken_q(taken_q)
    );

    function automatic string req_of(input logic [4:0] op);
        if (op == 1 || op == 2) return "R2";
        if (op == 3 || op == 4) return "R3";
        if (op == 5 || op == 6) return "R4";
        if (op >= 7 && op <= 9) return "R5";
        if (op == 10) return "R6";
        if (op >= 16 && op <= 24) return "R7";
        return "R9";
    endfunction

    // returns {operand, flags {N,V,Z,C}, taken}
    function automatic logic [12:0] ref_model(input logic [4:0] op, input logic [7:0] opc,
            input logic [7:0] a, input logic [7:0] x, input logic [7:0] y,
            input logic [7:0] m, input logic [3:0] f);
        logic [7:0] mo = m;
        logic [3:0] fo = f;
        logic       t  = 1'b0;
        logic [7:0] lhs, rhs, d;
        case (op)
            5'd1: begin fo[1] = ((m & a) == 0); fo[3] = m[7]; fo[2] = m[6]; end
            5'd2: fo[1] = ((m & a) == 0);
            5'd3: begin fo[1] = ((m & a) == 0); mo = m & ~a; end
            5'd4: begin fo[1] = ((m & a) == 0); mo = m | a; end
            5'd5: mo[opc[6:4]] = 1'b0;
            5'd6: mo[opc[6:4]] = 1'b1;
            5'd7, 5'd8, 5'd9, 5'd10: begin
                lhs = (op == 8) ? x : (op == 9) ? y : a;
                rhs = (op == 10) ? m - 8'd1 : m;
                if (op == 10) mo = rhs;
                d = lhs - rhs;
                fo[0] = (rhs <= lhs); fo[1] = (d == 0); fo[3] = d[7];
            end
            5'd16: t = !f[3];
            5'd17: t = f[3];
            5'd18: t = !f[2];
            5'd19: t = f[2];
            5'd20: t = !f[0];
            5'd21: t = f[0];
            5'd22: t = !f[1];
            5'd23: t = f[1];
            5'd24: t = 1'b1;
            default: ;
        endcase
        return {mo, fo, t};
    endfunction

    task automatic check(input string req, input string what, input logic [7:0] act,
            input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // R10: drive, one rising edge, then compare
    task automatic run_op(input logic [4:0] op, input logic [7:0] opc, input logic [7:0] a,
            input logic [7:0] x, input logic [7:0] y, input logic [7:0] m, input logic [3:0] f);
        logic [12:0] e;
        string r;
        op_code = op; opcode = opc; reg_a = a; reg_x = x; reg_y = y; opnd_in = m; flags_in = f;
        e = ref_model(op, opc, a, x, y, m, f);
        r = req_of(op);
        @(posedge clk); #1;
        check(r, "operand", opnd_q, e[12:5]);
        check(r, "flags", {4'd0, flags_q}, {4'd0, e[4:1]});
        check((op >= 16 && op <= 24) ? "R7" : "R8", "taken", {7'd0, taken_q}, {7'd0, e[0]});
    endtask

    function automatic logic [7:0] pick8();
        logic [7:0] pool [5] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF};
        if ($urandom_range(1, 0) == 1) return pool[$urandom_range(4, 0)];
        return 8'($urandom);
    endfunction

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] a, m;
        void'($urandom(32'd1234));
        rst = 1'b1; op_code = 5'd24; opcode = 8'hFF; reg_a = 8'hFF; reg_x = 8'hFF;
        reg_y = 8'hFF; opnd_in = 8'hFF; flags_in = 4'hF;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "reset operand", opnd_q, 8'h00);
        check("R1", "reset flags", {4'd0, flags_q}, 8'h00);
        check("R1", "reset taken", {7'd0, taken_q}, 8'h00);
        rst = 1'b0;

        // directed corners
        run_op(5'd1, 8'h00, 8'h3F, 0, 0, 8'hC0, 4'b0001);   // R2: N,V from operand, Z set
        run_op(5'd2, 8'h00, 8'h01, 0, 0, 8'hC1, 4'b0000);   // R2: only Z
        run_op(5'd3, 8'h00, 8'h0F, 0, 0, 8'hFF, 4'b1111);   // R3
        run_op(5'd4, 8'h00, 8'hF0, 0, 0, 8'h0F, 4'b0000);   // R3
        run_op(5'd5, 8'h70, 0, 0, 0, 8'hFF, 4'b1010);       // R4 bit 7 clear
        run_op(5'd6, 8'hB0, 0, 0, 0, 8'h00, 4'b0101);       // R4 index ignores opcode bit 7
        run_op(5'd7, 0, 8'h42, 0, 0, 8'h42, 4'b0100);       // R5 equal: C and Z
        run_op(5'd8, 0, 0, 8'h00, 0, 8'h01, 4'b0000);       // R5 X less
        run_op(5'd9, 0, 0, 0, 8'h80, 8'h7F, 4'b0000);       // R5 Y
        run_op(5'd10, 0, 8'hFF, 0, 0, 8'h00, 4'b0000);      // R6 wrap to FF
        run_op(5'd10, 0, 8'h10, 0, 0, 8'h11, 4'b0000);      // R6 equal after decrement
        for (int b = 16; b <= 24; b++) begin
            run_op(5'(b), 0, 0, 0, 0, 8'h5A, 4'b0000);      // R7 flags clear
            run_op(5'(b), 0, 0, 0, 0, 8'hA5, 4'b1111);      // R7 flags set
        end
        run_op(5'd11, 0, 8'hFF, 0, 0, 8'h33, 4'b1011);      // R9
        run_op(5'd31, 0, 8'hFF, 0, 0, 8'hCC, 4'b0110);      // R9
        run_op(5'd0, 0, 8'hFF, 0, 0, 8'h12, 4'b1111);       // R8 no-op

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            a = pick8();
            m = ($urandom_range(7, 0) == 0) ? a : pick8();
            run_op(5'($urandom), 8'($urandom), a, pick8(), pick8(), m, 4'($urandom));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule